// File: doc/BRIEF.md
# Chip-Selected Two-Wire Configuration Register Slave

This block lets a host on a shared two-wire serial bus (SMBus/I2C signalling) read and write a small bank of 8-bit configuration registers. It runs on a system clock that is much faster than the bus clock. Each bus line passes through a synchronizer and a glitch filter. The block then finds START, repeated START and STOP conditions and shifts bytes in and out. It drives the data line only by pulling it low, through an output enable.

An active-high chip-select input decides whether the block takes part in the bus at all. With the select low, the slave stays silent and ignores every transfer, so the host can talk to other devices on the same wires. The slave answers to the 7-bit address 0x56. A write is one address byte, one register-address byte and one data byte. A read sets the register address with a write phase and then issues a repeated START with the read bit set. Register 0 bit 0 is exported as a standby control, and the bus stays fully usable while it is set. A bus-idle flag reports a free bus after either of two timeouts.

Top module: `cfg_smbus_slave`

## Requirements
- R1: While `cs_i` is low the slave never asserts `sda_oe_o`, never acknowledges, and no register changes. Any transfer in progress is dropped.
- R2: Only an address byte whose upper seven bits equal 0x56 is acknowledged, so write 0xAC and read 0xAD. Any other address gets no ACK, and the slave waits for the next START.
- R3: A write is START, 0xAC, register address, data byte and STOP. Each of the three bytes gets an ACK, which is SDA held low during the ninth SCL-high period. The data byte lands in the addressed register.
- R4: A read is START, 0xAC, register address, repeated START and 0xAD. All three bytes are acknowledged. The slave then shifts out the addressed register MSB first, one bit per SCL-high period.
- R5: After the read data byte, a host NACK (SDA high on the ninth clock) leaves SDA released. Further clocks before a STOP or START see no drive from the slave.
- R6: Registers 0 to 2 are read/write, with reset values 0x00, 0x20 and 0x40. Address 3 is read-only and returns the ID value 0x6B. Writes to address 3 or to any address of 4 or above are acknowledged and change nothing, and reads of addresses 4 and above return 0x00.
- R7: A START in any state restarts the address phase. A STOP in any state aborts the transfer without a register write.
- R8: `bus_idle_o` rises once both lines have been high for more than 50 cycles after a STOP, or for more than 400 cycles without one. It falls after a START.
- R9: A pulse on SCL that lasts fewer than 3 system clocks is filtered out and shifts no bit.
- R10: `standby_o` mirrors register 0 bit 0. Reads and writes still work while it is 1.
- R11: After reset, `sda_oe_o` is 0, `cfg_o` is 0x402000, `standby_o` is 0 and `bus_idle_o` is 0.
- R12: `sda_oe_o` asserts only while SCL is low, so the slave never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select; high lets the slave take part in the bus |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Pull data line low when 1; release when 0 |
| cfg_o | output | NUM_REGS*8 | Read/write register contents, register 0 in the low byte |
| standby_o | output | 1 | Standby control taken from register 0 bit 0 |
| bus_idle_o | output | 1 | Bus judged free after a timeout |

## Verification
A repeated START and the write-data shifter can act in the same cycle. After the register-address ACK the slave is already collecting a data byte. The host then raises SCL with SDA high, which shifts one bit, and a START follows in that same high period. The START must win, and no commit may take place. Every read in the stimulus table triggers this case. The bench judges it in two ways: the read must return the right byte, and every register visible on `cfg_o` must hold its modelled value.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_REGA, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK, ST_WSTOP
   } smb_st_e;

   localparam logic [7:0] UNIMPL_RD = 8'h00;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic flt_o
);
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= {SYNC_STAGES{1'b1}};
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   generate
      if (FILT_LEN <= 1) begin : g_nofilt
         logic out_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) out_q <= 1'b1;
            else         out_q <= sync_q[SYNC_STAGES-1];
         end
         assign flt_o = out_q;
      end else begin : g_filt
         localparam int unsigned CW = $clog2(FILT_LEN);
         logic [CW-1:0] cnt_q;
         logic          out_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] == out_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
               out_q <= sync_q[SYNC_STAGES-1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign flt_o = out_q;
      end
   endgenerate
endmodule

// File: rtl/smb_bus_mon.sv
module smb_bus_mon #(
   parameter int unsigned BUS_FREE_CYC = 50,
   parameter int unsigned HIGH_MAX_CYC = 400
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o,
   output logic idle_o
);
   localparam int unsigned LIM = ((BUS_FREE_CYC > HIGH_MAX_CYC) ? BUS_FREE_CYC : HIGH_MAX_CYC) + 1;
   localparam int unsigned CW  = $clog2(LIM + 1);

   logic          scl_q, sda_q, after_stop_q;
   logic [CW-1:0] hi_cnt_q;

   assign start_o = scl_q && scl_i && sda_q && !sda_i;
   assign stop_o  = scl_q && scl_i && !sda_q && sda_i;
   assign rise_o  = !scl_q && scl_i;
   assign fall_o  = scl_q && !scl_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_q        <= 1'b1;
         sda_q        <= 1'b1;
         after_stop_q <= 1'b0;
         hi_cnt_q     <= '0;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
         if (stop_o)       after_stop_q <= 1'b1;
         else if (start_o) after_stop_q <= 1'b0;
         if (!(scl_i && sda_i))        hi_cnt_q <= '0;
         else if (hi_cnt_q != CW'(LIM)) hi_cnt_q <= hi_cnt_q + 1'b1;
      end
   end

   assign idle_o = (after_stop_q && (hi_cnt_q > CW'(BUS_FREE_CYC))) ||
                   (hi_cnt_q > CW'(HIGH_MAX_CYC));
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
   import smb_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h56
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       cs_i,
   input  logic       sda_i,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       scl_rise_i,
   input  logic       scl_fall_i,
   input  logic [7:0] rd_data_i,
   output logic       sda_oe_o,
   output logic       wr_en_o,
   output logic [7:0] ptr_o,
   output logic [7:0] wr_data_o
);
   smb_st_e    st_q, ret_q;
   logic [3:0] bitc_q;
   logic [7:0] rx_q, tx_q, ptr_q;
   logic       oe_q, byte_end;

   assign byte_end  = scl_fall_i && (bitc_q == 4'd8);
   assign wr_en_o   = cs_i && !start_i && !stop_i && (st_q == ST_WDAT) && byte_end;
   assign ptr_o     = ptr_q;
   assign wr_data_o = rx_q;
   assign sda_oe_o  = oe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         ret_q  <= ST_IDLE;
         bitc_q <= '0;
         rx_q   <= '0;
         tx_q   <= '0;
         ptr_q  <= '0;
         oe_q   <= 1'b0;
      end else if (!cs_i) begin
         st_q <= ST_IDLE;
         oe_q <= 1'b0;
      end else if (start_i) begin
         st_q   <= ST_ADDR;
         bitc_q <= '0;
         oe_q   <= 1'b0;
      end else if (stop_i) begin
         st_q <= ST_IDLE;
         oe_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_ADDR, ST_REGA, ST_WDAT: begin
               if (scl_rise_i && bitc_q != 4'd8) begin
                  rx_q   <= {rx_q[6:0], sda_i};
                  bitc_q <= bitc_q + 4'd1;
               end else if (byte_end) begin
                  bitc_q <= '0;
                  oe_q   <= 1'b1;
                  st_q   <= ST_ACK;
                  if (st_q == ST_ADDR) begin
                     if (rx_q[7:1] != DEV_ADDR) begin
                        oe_q <= 1'b0;
                        st_q <= ST_IDLE;
                     end
                     ret_q <= rx_q[0] ? ST_RDAT : ST_REGA;
                  end else if (st_q == ST_REGA) begin
                     ptr_q <= rx_q;
                     ret_q <= ST_WDAT;
                  end else begin
                     ret_q <= ST_WSTOP;
                  end
               end
            end
            ST_ACK: if (scl_fall_i) begin
               st_q <= ret_q;
               if (ret_q == ST_RDAT) begin
                  oe_q <= ~rd_data_i[7];
                  tx_q <= {rd_data_i[6:0], 1'b0};
               end else begin
                  oe_q <= 1'b0;
               end
            end
            ST_RDAT: if (scl_fall_i) begin
               if (bitc_q == 4'd7) begin
                  oe_q <= 1'b0;
                  st_q <= ST_RACK;
               end else begin
                  oe_q   <= ~tx_q[7];
                  tx_q   <= {tx_q[6:0], 1'b0};
                  bitc_q <= bitc_q + 4'd1;
               end
            end
            ST_RACK: if (scl_rise_i) st_q <= ST_WSTOP;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
   import smb_cfg_pkg::*;
#(
   parameter int unsigned              NUM_REGS = 3,
   parameter logic [NUM_REGS*8-1:0]    REG_RST  = '0,
   parameter logic [7:0]               ID_VAL   = 8'h6B
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic [7:0]            addr_i,
   input  logic [7:0]            wr_data_i,
   output logic [7:0]            rd_data_o,
   output logic [NUM_REGS*8-1:0] cfg_o
);
   for (genvar gr = 0; gr < NUM_REGS; gr++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                q <= REG_RST[gr*8 +: 8];
         else if (wr_en_i && addr_i == 8'(gr))       q <= wr_data_i;
      end
      assign cfg_o[gr*8 +: 8] = q;
   end

   always_comb begin
      rd_data_o = UNIMPL_RD;
      if (addr_i == 8'(NUM_REGS)) rd_data_o = ID_VAL;
      for (int i = 0; i < NUM_REGS; i++)
         if (addr_i == 8'(i)) rd_data_o = cfg_o[i*8 +: 8];
   end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
   parameter logic [6:0]            DEV_ADDR     = 7'h56,
   parameter int unsigned           NUM_REGS     = 3,
   parameter logic [NUM_REGS*8-1:0] REG_RST      = 24'h402000,
   parameter logic [7:0]            ID_VAL       = 8'h6B,
   parameter int unsigned           SYNC_STAGES  = 2,
   parameter int unsigned           FILT_LEN     = 3,
   parameter int unsigned           BUS_FREE_CYC = 50,
   parameter int unsigned           HIGH_MAX_CYC = 400
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cs_i,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] cfg_o,
   output logic                  standby_o,
   output logic                  bus_idle_o
);
   localparam int unsigned NLINES = 2;

   if (NUM_REGS < 1 || NUM_REGS > 254) begin : g_bad_regs
      $error("NUM_REGS must be 1..254");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BUS_FREE_CYC < 1 || HIGH_MAX_CYC < 1) begin : g_bad_tmo
      $error("timeouts must be nonzero");
   end

   logic [NLINES-1:0] raw, flt;
   logic scl_f, sda_f, start_w, stop_w, rise_w, fall_w, wr_en;
   logic [7:0] ptr, wr_data, rd_data;

   assign raw = {sda_i, scl_i};

   for (genvar gl = 0; gl < NLINES; gl++) begin : g_line
      smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_flt (
         .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw[gl]), .flt_o(flt[gl]));
   end
   assign scl_f = flt[0];
   assign sda_f = flt[1];

   smb_bus_mon #(.BUS_FREE_CYC(BUS_FREE_CYC), .HIGH_MAX_CYC(HIGH_MAX_CYC)) u_mon (
      .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
      .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w),
      .idle_o(bus_idle_o));

   smb_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .sda_i(sda_f),
      .start_i(start_w), .stop_i(stop_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
      .rd_data_i(rd_data), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .ptr_o(ptr),
      .wr_data_o(wr_data));

   smb_reg_bank #(.NUM_REGS(NUM_REGS), .REG_RST(REG_RST), .ID_VAL(ID_VAL)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(ptr),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .cfg_o(cfg_o));

   assign standby_o = cfg_o[0];
endmodule

// File: rtl/cfg_smbus_slave_chk.sv
module cfg_smbus_slave_chk #(
   parameter int unsigned NUM_REGS = 3
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  cs_i,
   input logic                  scl_f,
   input logic                  start_w,
   input logic                  sda_oe_o,
   input logic [NUM_REGS*8-1:0] cfg_o,
   input logic                  bus_idle_o
);
   p_cs_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_i |=> !sda_oe_o);

   p_cs_nowrite_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_i |=> $stable(cfg_o));

   p_start_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_w |=> !sda_oe_o);

   p_start_ends_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_w |=> !bus_idle_o);

   p_drive_on_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sda_oe_o) |-> !scl_f);
endmodule

bind cfg_smbus_slave cfg_smbus_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .scl_f(scl_f), .start_w(start_w),
   .sda_oe_o(sda_oe_o), .cfg_o(cfg_o), .bus_idle_o(bus_idle_o));

// File: tb/cfg_smbus_slave_tb.sv
`timescale 1ns/1ps
module cfg_smbus_slave_tb;
   localparam int Q = 12;
   localparam int NV = 15;
   // entry: {req[3:0], wr, addr[7:0], data[7:0]}; for reads data is the expected byte
   localparam logic [20:0] VEC [NV] = '{
      {4'd4,  1'b0, 8'h01, 8'h20},   // R4 reset value of reg 1
      {4'd4,  1'b0, 8'h02, 8'h40},   // R4 reset value of reg 2
      {4'd3,  1'b1, 8'h01, 8'h3C},   // R3
      {4'd4,  1'b0, 8'h01, 8'h3C},   // R4
      {4'd3,  1'b1, 8'h02, 8'hC3},   // R3
      {4'd4,  1'b0, 8'h02, 8'hC3},   // R4
      {4'd6,  1'b1, 8'h03, 8'hFF},   // R6 read-only
      {4'd6,  1'b0, 8'h03, 8'h6B},   // R6 ID value
      {4'd6,  1'b1, 8'h09, 8'h77},   // R6 unimplemented
      {4'd6,  1'b0, 8'h09, 8'h00},   // R6 reads zero
      {4'd10, 1'b1, 8'h00, 8'h01},   // R10 standby on
      {4'd10, 1'b0, 8'h01, 8'h3C},   // R10 read in standby
      {4'd10, 1'b1, 8'h02, 8'h5A},   // R10 write in standby
      {4'd10, 1'b0, 8'h02, 8'h5A},   // R10
      {4'd10, 1'b1, 8'h00, 8'h00}    // R10 standby off
   };

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b1, scl_h = 1'b1, sda_h = 1'b1, glitch = 1'b0;
   logic sda_oe, standby, bus_idle;
   logic [23:0] cfg;
   wire  sda_bus = sda_h & ~sda_oe;
   logic [7:0] mdl [3];
   int n_chk = 0, n_bad = 0, cs_viol = 0, hi_viol = 0;
   logic oe_prev = 1'b0, quiet_mon = 1'b0;
   int   quiet_viol = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   cfg_smbus_slave u_dut (
      .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .scl_i(scl_h & ~glitch | glitch),
      .sda_i(sda_bus), .sda_oe_o(sda_oe), .cfg_o(cfg), .standby_o(standby),
      .bus_idle_o(bus_idle));

   always @(posedge clk) begin
      if (!cs && sda_oe) cs_viol++;
      if (sda_oe && !oe_prev && scl_h) hi_viol++;
      if (quiet_mon && sda_oe) quiet_viol++;
      oe_prev <= sda_oe;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wt(int n); repeat (n) @(negedge clk); endtask

   task automatic h_start();
      sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(2*Q); sda_h = 1'b0; wt(2*Q); scl_h = 1'b0; wt(Q);
   endtask

   task automatic h_stop();
      sda_h = 1'b0; wt(Q); scl_h = 1'b1; wt(2*Q); sda_h = 1'b1; wt(2*Q);
   endtask

   task automatic h_bit(input logic b, input bit glt, output logic r);
      sda_h = b;
      if (glt) begin wt(Q/2); glitch = 1'b1; wt(2); glitch = 1'b0; wt(Q/2 - 2); end
      else wt(Q);
      scl_h = 1'b1; wt(Q); r = sda_bus; wt(Q); scl_h = 1'b0; wt(Q);
   endtask

   task automatic h_send(input logic [7:0] b, input bit glt, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) h_bit(b[i], glt && (i == 7), r);
      h_bit(1'b1, 1'b0, r);
      ack = ~r;
   endtask

   task automatic h_recv(output logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) begin h_bit(1'b1, 1'b0, r); b[i] = r; end
   endtask

   task automatic h_write(input logic [7:0] a, input logic [7:0] d, input bit glt,
                          output logic [2:0] acks);
      h_start();
      h_send(8'hAC, 1'b0, acks[2]);
      h_send(a, 1'b0, acks[1]);
      h_send(d, glt, acks[0]);
      h_stop();
   endtask

   task automatic h_read(input logic [7:0] a, output logic [7:0] d, output logic [2:0] acks);
      logic r;
      h_start();
      h_send(8'hAC, 1'b0, acks[2]);
      h_send(a, 1'b0, acks[1]);
      h_start();
      h_send(8'hAD, 1'b0, acks[0]);
      h_recv(d);
      h_bit(1'b1, 1'b0, r);
      h_stop();
   endtask

   function automatic logic [23:0] mdl_cfg();
      return {mdl[2], mdl[1], mdl[0]};
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      logic [2:0] acks;
      logic [7:0] d;
      logic r;
      mdl[0] = 8'h00; mdl[1] = 8'h20; mdl[2] = 8'h40;
      wt(5); rst_n = 1'b1; wt(20);
      // R11 reset state
      chk("R11 oe", sda_oe, 0);
      chk("R11 cfg", cfg, 24'h402000);
      chk("R11 standby", standby, 0);
      chk("R11 idle", bus_idle, 0);
      wt(450);
      chk("R8 idle after high-max time", bus_idle, 1);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[v][20:17], v);
         if (VEC[v][16]) begin
            h_write(VEC[v][15:8], VEC[v][7:0], 1'b0, acks);
            if (VEC[v][15:8] < 8'd3) mdl[VEC[v][15:8]] = VEC[v][7:0];
            chk({tag, " acks"}, acks, 3'b111);
            chk({tag, " cfg"}, cfg, mdl_cfg());
            chk({tag, " standby"}, standby, mdl[0][0]);
         end else begin
            h_read(VEC[v][15:8], d, acks);
            chk({tag, " acks"}, acks, 3'b111);
            chk({tag, " data"}, d, VEC[v][7:0]);
            chk({tag, " cfg kept"}, cfg, mdl_cfg());
         end
         wt(80);
      end

      // R2 wrong address gets no ACK
      h_start(); h_send(8'hAE, 1'b0, acks[2]); h_send(8'h01, 1'b0, acks[1]);
      h_send(8'h11, 1'b0, acks[0]); h_stop();
      chk("R2 no ack wrong addr", acks, 3'b000);
      chk("R2 cfg unchanged", cfg, mdl_cfg());

      // R1 chip select low: silent, no write
      cs = 1'b0; wt(10);
      h_write(8'h01, 8'h99, 1'b0, acks);
      chk("R1 no ack cs low", acks, 3'b000);
      chk("R1 cfg unchanged", cfg, mdl_cfg());
      chk("R1 no drive cs low", cs_viol, 0);
      cs = 1'b1; wt(10);

      // R7 stop aborts, then a normal write works
      h_start(); h_send(8'hAC, 1'b0, acks[2]); h_send(8'h01, 1'b0, acks[1]); h_stop();
      chk("R7 abort acks", acks[2:1], 2'b11);
      chk("R7 abort no write", cfg, mdl_cfg());
      h_write(8'h01, 8'hE7, 1'b0, acks); mdl[1] = 8'hE7;
      chk("R7 after abort", cfg, mdl_cfg());

      // R8 bus-free timeout after STOP
      wt(10);
      chk("R8 not idle yet", bus_idle, 0);
      wt(60);
      chk("R8 idle after bus free", bus_idle, 1);

      // R9 short SCL glitch ignored
      h_write(8'h02, 8'h96, 1'b1, acks); mdl[2] = 8'h96;
      chk("R9 glitch acks", acks, 3'b111);
      chk("R9 glitch data", cfg, mdl_cfg());

      // R5 after NACK further clocks see no drive
      h_start(); h_send(8'hAC, 1'b0, acks[2]); h_send(8'h01, 1'b0, acks[1]);
      h_start(); h_send(8'hAD, 1'b0, acks[0]); h_recv(d);
      h_bit(1'b1, 1'b0, r);
      quiet_mon = 1'b1;
      for (int k = 0; k < 9; k++) h_bit(1'b1, 1'b0, r);
      quiet_mon = 1'b0;
      h_stop();
      chk("R5 read data", d, mdl[1]);
      chk("R5 released after nack", quiet_viol, 0);

      chk("R12 drive only while scl low", hi_viol, 0);
      done = 1'b1;
      summary();
   end
endmodule